// File: doc/BRIEF.md
# Dual-Mode Branch-and-Link Unit

This unit decides where a branch goes and what gets written into the link register on a 32-bit machine with two addressing modes. In narrow mode an address is 24 bits. In wide mode it is 31 bits. The most significant bit of an address word (bit 31 in this project's numbering) picks the mode whenever a branch may switch modes. In narrow mode the top byte is ignored, and in wide mode only the top bit is ignored.

Each cycle the unit receives one decoded branch operation. With it come:
- the register fields,
- the two register operand values,
- the updated instruction address (the return address),
- the condition code and the program mask.

In the same cycle it produces, combinationally:
- the next instruction address,
- the mode that will be in force afterwards,
- a link word with its write enable,
- a taken strobe.

The current mode is the unit's only state. It is held in a two-state machine with the states `AM_24` and `AM_31`. On a taken mode-saving call or mode-setting return whose target word has bit 31 set, the machine makes the `TO_31` transition from `AM_24`. When that bit is clear, it makes the `TO_24` transition from `AM_31`. In every other case the machine stays in its current state.

Four kinds of linkage are supported:
- a status link, which packs status bits into the top byte of the link word;
- an address link, which stores only the return address;
- a mode-saving call, which records the caller's mode and switches to the callee's mode;
- a mode-setting return, which switches back to the mode stored in the target word.

Top module: `dual_mode_branch_link`

## Requirements
- R1: After reset the mode is narrow (`mode_cur`=0). When `br_valid` is 0, or when `br_op` is 0 or 7, `taken` and `link_we` are 0, the mode does not change, and `target_addr` is `ret_addr` masked to the current mode.
- R2: The status link ops are 1 (register form) and 2 (indexed form). Their link word is laid out as follows:
  - bits 31:30 hold the length code;
  - bits 29:28 hold `cond_code`;
  - bits 27:24 hold `prog_mask`;
  - bits 23:0 hold `ret_addr[23:0]`.
  Bit 31 of this word is therefore always 0, in either mode.
- R3: The length code in a status link word is 00 for op 1 and 01 for op 2.
- R4: The address link ops are 3 (register form) and 4 (indexed form). In narrow mode the link word is `{8'h00, ret_addr[23:0]}`. In wide mode it is `{1'b1, ret_addr[30:0]}`.
- R5: The mode-saving call is op 5. It writes the same return word as R4, built with the caller's mode. The new mode is `r2_val[31]`, and the target is `r2_val` masked to that new mode.
- R6: The mode-setting return is op 6. The new mode is `r2_val[31]`, and the target is `r2_val` masked to that new mode. If `r1_field` is 0, nothing is written. Otherwise the link word is `r1_val` with bit 31 replaced by the current mode.
- R7: Every target is masked to the mode in force after the branch:
  - in narrow mode, bits 31:24 are 0;
  - in wide mode, bit 31 is 0.
- R8: The register forms are ops 1, 3, 5 and 6. When one of them has `r2_field`=0, the branch is not taken and no link is written.
- R9: The status link and address link ops never change the mode. The mode register loads `mode_next` on the clock edge.
- R10: A call followed by a return through the saved link word restores the caller's mode and return address. This holds for all four narrow/wide caller/callee pairings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; selects narrow mode |
| br_valid | input | 1 | A branch operation is present this cycle |
| br_op | input | 3 | Operation code: 0 none, 1/2 status link, 3/4 address link, 5 call, 6 return |
| r1_field | input | 4 | First register field |
| r2_field | input | 4 | Second register field (target register for register forms) |
| cond_code | input | 2 | Current condition code |
| prog_mask | input | 4 | Current program mask |
| ret_addr | input | 32 | Updated instruction address |
| r1_val | input | 32 | Value of the first register operand |
| r2_val | input | 32 | Branch target operand |
| target_addr | output | 32 | Next instruction address |
| mode_next | output | 1 | Mode after this operation (1 = wide) |
| link_data | output | 32 | Link word (0 when `link_we` is 0) |
| link_we | output | 1 | Link register write enable |
| taken | output | 1 | Branch taken strobe |
| mode_cur | output | 1 | Mode currently in force |

## Verification
The target, the next mode, the link word, its enable and the taken strobe are all due in the same cycle as the operation that produces them. `mode_cur` changes only at the following rising edge. The driver applies each operation just after a falling edge and pushes the expected item. The monitor pops and compares that item 2 ns later, still within the same cycle. At that point the expected `mode_cur` is still the mode from before the operation. Any mode change is therefore seen by the monitor as the pre-operation mode of the next item.

// File: rtl/bl_pkg.sv
package bl_pkg;

    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_STAT_R = 3'd1,
        OP_STAT_X = 3'd2,
        OP_ADDR_R = 3'd3,
        OP_ADDR_X = 3'd4,
        OP_CALL_R = 3'd5,
        OP_RET_R  = 3'd6,
        OP_RSVD   = 3'd7
    } brop_e;

    typedef enum logic {
        AM_24 = 1'b0,
        AM_31 = 1'b1
    } amode_e;

endpackage

// File: rtl/bl_target.sv
module bl_target
    import bl_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int NARROW_AW = 24
) (
    input  amode_e            mode_after,
    input  logic [XLEN-1:0]   raw,
    output logic [XLEN-1:0]   masked
);

    // Per bit: low bits always pass, mid bits pass only in wide mode,
    // the top bit never passes.
    for (genvar i = 0; i < XLEN; i++) begin : g_bit
        if (i < NARROW_AW) begin : g_low
            assign masked[i] = raw[i];
        end else if (i < XLEN - 1) begin : g_mid
            assign masked[i] = raw[i] & (mode_after == AM_31);
        end else begin : g_top
            assign masked[i] = 1'b0;
        end
    end

endmodule

// File: rtl/bl_link.sv
module bl_link
    import bl_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int NARROW_AW = 24,
    parameter int CC_W      = 2,
    parameter int PM_W      = 4
) (
    input  brop_e             op,
    input  amode_e            mode,
    input  logic [CC_W-1:0]   cond_code,
    input  logic [PM_W-1:0]   prog_mask,
    input  logic [XLEN-1:0]   ret_addr,
    input  logic [XLEN-1:0]   r1_val,
    output logic [XLEN-1:0]   word
);

    localparam int TOP_W = XLEN - NARROW_AW;
    localparam int ILC_W = TOP_W - CC_W - PM_W;
    localparam logic [ILC_W-1:0] ILC_SHORT = ILC_W'(0);
    localparam logic [ILC_W-1:0] ILC_LONG  = ILC_W'(1);

    logic [XLEN-1:0] addr_word;

    always_comb begin
        if (mode == AM_31) begin
            addr_word = {1'b1, ret_addr[XLEN-2:0]};
        end else begin
            addr_word = {{TOP_W{1'b0}}, ret_addr[NARROW_AW-1:0]};
        end
    end

    always_comb begin
        unique case (op)
            OP_STAT_R: word = {ILC_SHORT, cond_code, prog_mask, ret_addr[NARROW_AW-1:0]};
            OP_STAT_X: word = {ILC_LONG,  cond_code, prog_mask, ret_addr[NARROW_AW-1:0]};
            OP_ADDR_R,
            OP_ADDR_X,
            OP_CALL_R: word = addr_word;
            OP_RET_R:  word = {mode == AM_31, r1_val[XLEN-2:0]};
            default:   word = '0;
        endcase
    end

endmodule

// File: rtl/dual_mode_branch_link.sv
module dual_mode_branch_link
    import bl_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int NARROW_AW = 24,
    parameter int RF_W      = 4,
    parameter int CC_W      = 2,
    parameter int PM_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_valid,
    input  logic [2:0]        br_op,
    input  logic [RF_W-1:0]   r1_field,
    input  logic [RF_W-1:0]   r2_field,
    input  logic [CC_W-1:0]   cond_code,
    input  logic [PM_W-1:0]   prog_mask,
    input  logic [XLEN-1:0]   ret_addr,
    input  logic [XLEN-1:0]   r1_val,
    input  logic [XLEN-1:0]   r2_val,
    output logic [XLEN-1:0]   target_addr,
    output logic              mode_next,
    output logic [XLEN-1:0]   link_data,
    output logic              link_we,
    output logic              taken,
    output logic              mode_cur
);

    localparam int MSB = XLEN - 1;

    brop_e           op;
    amode_e          state_q, state_d;
    logic            reg_form, known_op, blocked, go, sets_mode, tgt_wide;
    logic [XLEN-1:0] raw_tgt, link_word;

    // Decode of the operation.
    always_comb begin
        op        = brop_e'(br_op);
        reg_form  = (op == OP_STAT_R) || (op == OP_ADDR_R) ||
                    (op == OP_CALL_R) || (op == OP_RET_R);
        known_op  = (op != OP_NONE) && (op != OP_RSVD);
        blocked   = reg_form && (r2_field == '0);
        go        = br_valid && known_op && !blocked;
        sets_mode = (op == OP_CALL_R) || (op == OP_RET_R);
        tgt_wide  = r2_val[MSB];
    end

    // Next-state logic: TO_31 / TO_24 on a taken mode-switching op.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            AM_24: if (go && sets_mode && tgt_wide)  state_d = AM_31;
            AM_31: if (go && sets_mode && !tgt_wide) state_d = AM_24;
            default: state_d = AM_24;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= AM_24;
        else        state_q <= state_d;
    end

    bl_link #(
        .XLEN(XLEN), .NARROW_AW(NARROW_AW), .CC_W(CC_W), .PM_W(PM_W)
    ) u_link (
        .op(op), .mode(state_q), .cond_code(cond_code), .prog_mask(prog_mask),
        .ret_addr(ret_addr), .r1_val(r1_val), .word(link_word)
    );

    bl_target #(
        .XLEN(XLEN), .NARROW_AW(NARROW_AW)
    ) u_target (
        .mode_after(state_d), .raw(raw_tgt), .masked(target_addr)
    );

    // Output process.
    always_comb begin
        raw_tgt   = go ? r2_val : ret_addr;
        taken     = go;
        mode_next = (state_d == AM_31);
        mode_cur  = (state_q == AM_31);
        link_we   = go && !((op == OP_RET_R) && (r1_field == '0));
        link_data = link_we ? link_word : '0;
    end

    // Checks next to the logic.
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !br_valid |-> (!taken && !link_we));

    a_r8_zero_target_field: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && reg_form && r2_field == '0) |-> (!taken && !link_we));

    a_r7_narrow_target: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_next |-> (target_addr[MSB:NARROW_AW] == '0));

    a_r7_wide_target: assert property (@(posedge clk) disable iff (!rst_n)
        mode_next |-> !target_addr[MSB]);

    a_r9_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        !(br_valid && taken) |=> $stable(mode_cur));

    a_r2_status_top_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (link_we && (br_op == OP_STAT_R || br_op == OP_STAT_X)) |-> !link_data[MSB]);

    a_r6_no_save: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && br_op == OP_RET_R && r1_field == '0) |-> !link_we);

    a_r5_call_saves_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (link_we && br_op == OP_CALL_R) |-> (link_data[MSB] == mode_cur));

endmodule

// File: tb/tb_dual_mode_branch_link.sv
`timescale 1ns/1ps
module tb_dual_mode_branch_link;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        br_valid = 1'b0;
    logic [2:0]  br_op = 3'd0;
    logic [3:0]  r1_field = 4'd0, r2_field = 4'd0;
    logic [1:0]  cond_code = 2'd0;
    logic [3:0]  prog_mask = 4'd0;
    logic [31:0] ret_addr = 32'd0, r1_val = 32'd0, r2_val = 32'd0;
    logic [31:0] target_addr, link_data;
    logic        mode_next, link_we, taken, mode_cur;

    always #5 clk = ~clk;

    dual_mode_branch_link dut (
        .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_op(br_op),
        .r1_field(r1_field), .r2_field(r2_field), .cond_code(cond_code),
        .prog_mask(prog_mask), .ret_addr(ret_addr), .r1_val(r1_val),
        .r2_val(r2_val), .target_addr(target_addr), .mode_next(mode_next),
        .link_data(link_data), .link_we(link_we), .taken(taken), .mode_cur(mode_cur)
    );

    typedef struct packed {
        logic        tk;
        logic [31:0] tgt;
        logic        we;
        logic [31:0] lnk;
        logic        mn;
        logic        mc;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_cmp = 0, n_bad = 0;
    logic  model_mode = 1'b0;
    logic  finished = 1'b0;
    logic [31:0] saved;

    function automatic logic [31:0] msk(input logic [31:0] v, input logic m);
        return m ? (v & 32'h7FFF_FFFF) : (v & 32'h00FF_FFFF);
    endfunction

    task automatic cmp(input logic [31:0] act, input logic [31:0] expv,
                       input string tag, input string what);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    task automatic drive(input logic vld, input logic [2:0] op,
                         input logic [3:0] f1, input logic [3:0] f2,
                         input logic [1:0] cc, input logic [3:0] pm,
                         input logic [31:0] ia, input logic [31:0] v1,
                         input logic [31:0] v2, input string tag);
        exp_t e;
        logic regf, known, go, nm;
        @(negedge clk);
        br_valid = vld; br_op = op; r1_field = f1; r2_field = f2;
        cond_code = cc; prog_mask = pm; ret_addr = ia; r1_val = v1; r2_val = v2;
        regf  = (op == 3'd1) || (op == 3'd3) || (op == 3'd5) || (op == 3'd6);
        known = (op >= 3'd1) && (op <= 3'd6);
        go    = vld && known && !(regf && f2 == 4'd0);
        nm    = model_mode;
        if (go && (op == 3'd5 || op == 3'd6)) nm = v2[31];
        e.tk  = go;
        e.tgt = go ? msk(v2, nm) : msk(ia, model_mode);
        e.we  = go && !(op == 3'd6 && f1 == 4'd0);
        case (op)
            3'd1: e.lnk = {2'b00, cc, pm, ia[23:0]};
            3'd2: e.lnk = {2'b01, cc, pm, ia[23:0]};
            3'd3, 3'd4, 3'd5:
                  e.lnk = model_mode ? {1'b1, ia[30:0]} : {8'h00, ia[23:0]};
            3'd6: e.lnk = {model_mode, v1[30:0]};
            default: e.lnk = 32'd0;
        endcase
        if (!e.we) e.lnk = 32'd0;
        e.mn = nm;
        e.mc = model_mode;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        if (e.we) saved = e.lnk;
        model_mode = nm;
    endtask

    // Monitor: compare each expected item in the cycle it was driven.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                cmp({31'd0, taken},   {31'd0, e.tk}, t, "taken");
                cmp(target_addr,      e.tgt,         t, "target");
                cmp({31'd0, link_we}, {31'd0, e.we}, t, "link_we");
                cmp(link_data,        e.lnk,         t, "link");
                cmp({31'd0, mode_next}, {31'd0, e.mn}, t, "mode_next");
                cmp({31'd0, mode_cur},  {31'd0, e.mc}, t, "mode_cur");
            end
        end
    end

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1: reset state
        cmp({31'd0, mode_cur}, 32'd0, "R1", "reset mode");
        cmp({31'd0, taken},    32'd0, "R1", "reset taken");
        cmp({31'd0, link_we},  32'd0, "R1", "reset link_we");

        // R2 R3: status links in narrow mode
        drive(1, 3'd1, 4'd14, 4'd15, 2'b10, 4'hA, 32'h0000_1002, 32'h0, 32'h8123_4567, "R3 status register form");
        drive(1, 3'd2, 4'd14, 4'd0,  2'b01, 4'hF, 32'hAB00_2006, 32'h0, 32'hFF00_3000, "R2 status indexed form");
        // R4: address link narrow
        drive(1, 3'd3, 4'd14, 4'd15, 2'b00, 4'h0, 32'hFF12_3456, 32'h0, 32'h0000_4000, "R4 address link narrow");
        // R8: zero target field
        drive(1, 3'd1, 4'd14, 4'd0,  2'b11, 4'h5, 32'h0000_5002, 32'h0, 32'h8000_6000, "R8 zero field status");
        drive(1, 3'd5, 4'd14, 4'd0,  2'b00, 4'h0, 32'h0000_5004, 32'h0, 32'h8000_6000, "R8 zero field call");
        // R1: idle and reserved codes
        drive(0, 3'd5, 4'd14, 4'd15, 2'b00, 4'h0, 32'h0000_5008, 32'h0, 32'h8000_7000, "R1 valid low");
        drive(1, 3'd7, 4'd14, 4'd15, 2'b00, 4'h0, 32'h0000_500A, 32'h0, 32'h8000_7000, "R1 reserved op");

        // R10: narrow calls wide, return restores narrow (R5, R6)
        drive(1, 3'd5, 4'd14, 4'd15, 2'b00, 4'h0, 32'h0000_2004, 32'h0, 32'h8765_4321, "R5 call 24 to 31");
        drive(1, 3'd4, 4'd14, 4'd0,  2'b00, 4'h0, 32'h0765_4400, 32'h0, 32'hC000_0100, "R4 address link wide");
        drive(1, 3'd1, 4'd14, 4'd12, 2'b01, 4'h3, 32'h0765_4402, 32'h0, 32'hFFFF_FFFE, "R2 status in wide mode");
        drive(1, 3'd6, 4'd0,  4'd14, 2'b00, 4'h0, 32'h0765_4404, 32'h0, 32'h0000_2004, "R10 return 31 to 24");

        // R10: narrow calls narrow
        drive(1, 3'd5, 4'd14, 4'd15, 2'b00, 4'h0, 32'h0000_2100, 32'h0, 32'h7F00_3000, "R10 call 24 to 24");
        drive(1, 3'd6, 4'd0,  4'd14, 2'b00, 4'h0, 32'h0000_3010, 32'h0, saved,         "R10 return 24 to 24");

        // into wide mode, then wide calls narrow
        drive(1, 3'd5, 4'd14, 4'd15, 2'b00, 4'h0, 32'h0000_2200, 32'h0, 32'h8000_0100, "R5 enter wide");
        drive(1, 3'd5, 4'd14, 4'd15, 2'b00, 4'h0, 32'h0123_4568, 32'h0, 32'h1200_5000, "R10 call 31 to 24");
        saved = 32'h8123_4568;
        // R6: nonzero first field saves current mode into bit 31
        drive(1, 3'd6, 4'd3,  4'd14, 2'b00, 4'h0, 32'h0000_5010, 32'h9234_5678, saved, "R6 return 24 to 31 with save");
        // R10: wide calls wide
        drive(1, 3'd5, 4'd14, 4'd15, 2'b00, 4'h0, 32'h0200_0000, 32'h0, 32'hA000_0040, "R10 call 31 to 31");
        drive(1, 3'd6, 4'd5,  4'd14, 2'b00, 4'h0, 32'h2000_0050, 32'h1234_5678, 32'h8200_0000, "R6 return 31 to 31 with save");
        // R9: status/address links in wide mode keep mode
        drive(1, 3'd3, 4'd14, 4'd15, 2'b00, 4'h0, 32'h0200_0010, 32'h0, 32'h0000_0100, "R9 address link keeps wide");
        drive(1, 3'd6, 4'd0,  4'd14, 2'b00, 4'h0, 32'h0000_0104, 32'h0, 32'h0000_0200, "R9 return to narrow");
        drive(0, 3'd0, 4'd0,  4'd0,  2'b00, 4'h0, 32'hFF00_0300, 32'h0, 32'h0, "R9 idle after return");

        @(negedge clk);
        #4;
        // R9: mode register loaded from the last return
        cmp({31'd0, mode_cur}, 32'd0, "R9", "final mode");
        finished = 1'b1;
        summary();
    end

endmodule